// File: doc/BRIEF.md
# Transposed Four-Tap FIR Filter

This block filters a stream of signed samples with a fixed four-coefficient impulse response. It computes a full-precision weighted sum of the current sample and the three samples accepted before it. Each accepted sample is fed to all four coefficient products at once. The partial sums travel through a chain of registers that sit between the adders. A sample is accepted in any cycle where the input strobe is high, and the filtered value for that sample appears one clock later with its own strobe.

The structure comes from the plain tapped-delay-line filter. The sum is first reordered so that the oldest term is added first. The delays are then moved off the sample line and into the sum chain. The longest combinational path is therefore one multiply and one add, whatever the number of taps. The coefficients are elaboration-time parameters and cannot change at run time. The output width is the sample width plus the coefficient width plus two growth bits, so no result is ever clipped or wrapped.

Top module: `tpf_filter`

## Requirements
- R1: Let k count accepted samples (in_valid high at a rising edge). The output for sample k is H0·x(k) + H1·x(k-1) + H2·x(k-2) + H3·x(k-3). It is presented on out_data, with out_valid high, in the cycle after x(k) is accepted.
- R2: While rst_n is low (asynchronous, active low), out_valid is 0 and out_data is 0. All stored partial sums are cleared.
- R3: Samples that were not accepted since the last reset count as zero. The first output after reset is H0·x(0), and the second is H0·x(1) + H1·x(0).
- R4: A cycle with in_valid low changes nothing. out_data keeps its value, and the next accepted sample gives the same result it would give with no idle cycle in between.
- R5: The result is exact for every input. The output stays within ±(|H0|+|H1|+|H2|+|H3|)·2^(SAMPLE_W-1), including when samples sit at the most negative and most positive two's-complement codes.
- R6: A unit impulse (one sample of value 1 followed by zeros) produces H0, H1, H2, H3 and then 0 on successive outputs.
- R7: out_valid is high for exactly one cycle per accepted sample, and never in the cycle after an idle one.
- R8: Elaboration fails if SAMPLE_W or COEF_W is below 2, or if any coefficient does not fit in COEF_W signed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_sample carries a new sample |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | High for one cycle when out_data carries a new result |
| out_data | output | SAMPLE_W+COEF_W+2 | Signed, full-precision filter output |

## Verification
The bench builds the filter with 12-bit samples and 10-bit coefficients. One coefficient is set to the most negative 10-bit code and one to the most positive, and the signs are mixed. With these values, sample patterns at the code limits drive the sum near its growth bound. Any truncation or sign-extension error in the product or chain widths then shows up in the output. A behavioural reference keeps a history of accepted samples and predicts each result. The stimulus includes an impulse, gaps between samples, a reset in mid-stream, and a long run of random samples with random strobes.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
   // fixed tap count of this filter
   localparam int NTAPS = 4;
   // extra result bits needed to add NTAPS full-width products
   localparam int GROWTH = $clog2(NTAPS);

   // magnitude of an integer coefficient
   function automatic longint mag(input longint v);
      return (v < 0) ? -v : v;
   endfunction
endpackage

// File: rtl/tpf_product.sv
// One coefficient product, sign-extended to the accumulator width.
module tpf_product #(
   parameter int SAMPLE_W = 12,
   parameter int ACC_W    = 24,
   parameter int COEF     = 1
) (
   input  logic signed [SAMPLE_W-1:0] sample_i,
   output logic signed [ACC_W-1:0]    prod_o
);
   localparam logic signed [ACC_W-1:0] CS = ACC_W'(COEF);

   logic signed [ACC_W-1:0] xs;

   assign xs     = ACC_W'(sample_i);
   assign prod_o = xs * CS;
endmodule

// File: rtl/tpf_stage.sv
// One link of the sum chain: adds a product to the partial sum arriving
// from the older side and registers it when a sample is accepted.
module tpf_stage #(
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv_i,
   input  logic signed [ACC_W-1:0] prod_i,
   input  logic signed [ACC_W-1:0] carry_i,
   output logic signed [ACC_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= '0;
      else if (adv_i) q_o <= prod_i + carry_i;
   end
endmodule

// File: rtl/tpf_filter.sv
module tpf_filter import tpf_pkg::*; #(
   parameter  int SAMPLE_W = 12,
   parameter  int COEF_W   = 10,
   parameter  int H0       = 3,
   parameter  int H1       = -5,
   parameter  int H2       = 7,
   parameter  int H3       = 2,
   localparam int ACC_W    = SAMPLE_W + COEF_W + GROWTH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   output logic                       out_valid,
   output logic signed [ACC_W-1:0]    out_data
);
   localparam int CMAX = (1 << (COEF_W - 1)) - 1;
   localparam int CMIN = -(1 << (COEF_W - 1));
   localparam int CF [NTAPS] = '{H0, H1, H2, H3};

   // R8: elaboration-time parameter checks
   if (SAMPLE_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("tpf_filter: SAMPLE_W and COEF_W must be at least 2");
   end
   for (genvar c = 0; c < NTAPS; c++) begin : g_coef_chk
      if (CF[c] > CMAX || CF[c] < CMIN) begin : g_bad_coef
         $error("tpf_filter: coefficient %0d out of range", c);
      end
   end

   // part[i] is stage i's register. part[NTAPS] is the zero feeding the
   // oldest stage, and part[0] is the output register.
   logic signed [ACC_W-1:0] part [NTAPS+1];
   logic signed [ACC_W-1:0] prod [NTAPS];

   assign part[NTAPS] = '0;

   for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      tpf_product #(
         .SAMPLE_W (SAMPLE_W),
         .ACC_W    (ACC_W),
         .COEF     (CF[i])
      ) u_prod (
         .sample_i (in_sample),
         .prod_o   (prod[i])
      );

      tpf_stage #(
         .ACC_W (ACC_W)
      ) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv_i   (in_valid),
         .prod_i  (prod[i]),
         .carry_i (part[i+1]),
         .q_o     (part[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign out_data = part[0];
endmodule

// File: rtl/tpf_filter_chk.sv
module tpf_filter_chk import tpf_pkg::*; #(
   parameter int SAMPLE_W = 12,
   parameter int ACC_W    = 24,
   parameter int H0 = 0,
   parameter int H1 = 0,
   parameter int H2 = 0,
   parameter int H3 = 0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic signed [ACC_W-1:0] out_data
);
   localparam longint PEAK = (mag(H0) + mag(H1) + mag(H2) + mag(H3))
                             * (longint'(1) << (SAMPLE_W - 1));

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_reset_clear_R2: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_data == '0));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(out_data) <= PEAK && longint'(out_data) >= -PEAK));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
endmodule

bind tpf_filter tpf_filter_chk #(
   .SAMPLE_W (SAMPLE_W),
   .ACC_W    (ACC_W),
   .H0 (H0), .H1 (H1), .H2 (H2), .H3 (H3)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_tpf_filter.sv
module sim_tpf_filter;
   localparam int SW = 12;
   localparam int CW = 10;
   localparam int AW = SW + CW + 2;
   localparam int K0 = -512;
   localparam int K1 = 300;
   localparam int K2 = -7;
   localparam int K3 = 511;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [SW-1:0] in_sample = '0;
   logic                 out_valid;
   logic signed [AW-1:0] out_data;

   int     n_checks = 0;
   int     n_fail   = 0;
   int     cycles   = 0;
   bit     done     = 0;
   longint hist [4];
   longint last_exp = 0;

   always #2.5 clk = ~clk;

   tpf_filter #(
      .SAMPLE_W (SW), .COEF_W (CW),
      .H0 (K0), .H1 (K1), .H2 (K2), .H3 (K3)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .in_sample (in_sample), .out_valid (out_valid), .out_data (out_data)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int i = 0; i < 4; i++) hist[i] = 0;
      last_exp = 0;
   endtask

   // Drive one cycle, then check the registered result after the edge.
   task automatic step(input bit v, input int x, input string req);
      longint e;
      @(negedge clk);
      in_valid  = v;
      in_sample = SW'(x);
      @(posedge clk);
      #1;
      if (v) begin
         for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = x;
         e = K0 * hist[0] + K1 * hist[1] + K2 * hist[2] + K3 * hist[3];
         last_exp = e;
         check({req, " valid"}, longint'(out_valid), 1);
      end else begin
         check({req, " idle valid"}, longint'(out_valid), 0);
      end
      check({req, " data"}, longint'(out_data), last_exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R2: outputs cleared while reset is held
      check("R2 reset valid", longint'(out_valid), 0);
      check("R2 reset data", longint'(out_data), 0);
      rst_n = 1'b1;
      clear_hist();
   endtask

   function automatic void finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
         end
      end
   end

   initial begin
      clear_hist();
      do_reset();

      // R3: first outputs use zero history
      step(1, 100, "R3 first");
      step(1, -37, "R3 second");

      // R6: unit impulse after flushing the history with zeros
      for (int i = 0; i < 4; i++) step(1, 0, "R6 flush");
      step(1, 1, "R6 impulse h0");
      check("R6 h0", longint'(out_data), K0);
      step(1, 0, "R6 impulse");
      check("R6 h1", longint'(out_data), K1);
      step(1, 0, "R6 impulse");
      check("R6 h2", longint'(out_data), K2);
      step(1, 0, "R6 impulse");
      check("R6 h3", longint'(out_data), K3);
      step(1, 0, "R6 impulse");
      check("R6 tail", longint'(out_data), 0);

      // R4 and R7: idle cycles between samples hold the output
      step(1, 250, "R1 pre-gap");
      step(0, 999, "R4 idle");
      step(0, -5, "R4 idle");
      step(1, -90, "R4 after gap");
      step(0, 17, "R7 idle");
      step(1, 33, "R4 after gap");

      // R5: samples at the code limits, signs chosen to push the sum up
      step(1, 2047, "R5 extreme");
      step(1, -2048, "R5 extreme");
      step(1, 2047, "R5 extreme");
      step(1, -2048, "R5 extreme");
      step(1, -2048, "R5 extreme");
      step(1, -2048, "R5 extreme");
      step(1, -2048, "R5 extreme");
      step(1, -2048, "R5 extreme");

      // R2 and R3: reset in mid-stream wipes the history
      do_reset();
      step(1, 421, "R3 after reset");

      // R1: random samples with random strobes
      for (int i = 0; i < 400; i++) begin
         int x;
         bit v;
         x = int'($urandom_range(4095)) - 2048;
         v = ($urandom_range(3) != 0);
         step(v, x, "R1 random");
      end

      finish_run();
   end
endmodule